// File: doc/BRIEF.md
# Nibble Parallel I/O Channel Bank

This block holds four 4-bit output latches, one per I/O channel, and drives each latch straight onto its group of four open-drain pins. A 2-bit channel operand picks the channel for every operation. A write operation copies a nibble into the chosen latch. The nibble comes either from the accumulator or from the secondary (sub-)accumulator. A pattern operation takes an 8-bit ROM word and loads both upper channels in the same cycle.

A read operation returns the chosen channel's pin value to one of the two accumulators. Because the latch keeps driving its pins during a read, the value returned is the bitwise AND of the latch and the external pin level. Firmware therefore writes all ones to a channel before sampling it as a true input.

One operation is accepted each clock. Latch writes appear on the pin outputs one cycle after the operation. A read result comes back, registered, one cycle after the read, together with a tag that names which accumulator it is for.

Top module: `nio_bank`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, every latch holds 4'hF, so `pin_out` is all ones and `rd_valid` is 0.
- R2: A write (`op` = 2'd1) with `src_sel` = 0 loads `acc_in` into the latch of channel `ch_sel`. Channel c drives `pin_out[4c+3:4c]`. The new value appears one cycle later, and the other channels keep their values.
- R3: A write with `src_sel` = 1 loads `sub_in` instead of `acc_in`.
- R4: A pattern operation (`op` = 2'd2) loads `pat_in[7:4]` into channel 3 and `pat_in[3:0]` into channel 2 in one cycle. Channels 0 and 1 are unchanged, and `ch_sel`, `src_sel`, `acc_in` and `sub_in` have no effect.
- R5: One cycle after a read (`op` = 2'd3), `rd_valid` is 1 and `rd_data` equals the selected latch ANDed bit by bit with `pin_in[4c+3:4c]`. Pins of the other channels do not affect the result.
- R6: `rd_to_sub` in the result cycle equals the `src_sel` given with the read (1 = sub-accumulator, 0 = accumulator).
- R7: A read and a no-op (`op` = 2'd0) leave every latch unchanged.
- R8: `rd_valid` is 1 only in the cycle after a read. In every other cycle it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op | input | 2 | 0 no-op, 1 write, 2 pattern, 3 read |
| ch_sel | input | 2 | Channel operand |
| src_sel | input | 1 | 0 accumulator, 1 sub-accumulator (source or destination) |
| acc_in | input | 4 | Accumulator value |
| sub_in | input | 4 | Sub-accumulator value |
| pat_in | input | 8 | ROM pattern word |
| pin_in | input | 16 | External pin levels, channel c at bits 4c+3:4c |
| pin_out | output | 16 | Latch values driving the pins |
| rd_valid | output | 1 | Read result valid |
| rd_to_sub | output | 1 | Read result goes to the sub-accumulator |
| rd_data | output | 4 | Wired-AND read result |

## Verification
The assertions assume that `op`, `ch_sel`, `src_sel` and the data inputs are known and steady around each rising edge. They also assume that `pin_in` is a plain level with no dependence on `pin_out` inside the cycle. The bench meets these assumptions by changing every input only on the falling edge and by choosing each pin level independently of the latch. The other channels' pin bits are held at zero during reads, so that any leakage from a neighbouring channel would show up in the result.

// File: rtl/nio_pkg.sv
package nio_pkg;
  typedef enum logic [1:0] {
    NIO_NOP     = 2'd0,
    NIO_WRITE   = 2'd1,
    NIO_PATTERN = 2'd2,
    NIO_READ    = 2'd3
  } nio_op_e;
endpackage

// File: rtl/nio_decode.sv
module nio_decode #(
  parameter int NUM_CH = 4,
  parameter int NIB_W  = 4,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic [1:0]                   op,
  input  logic [CH_W-1:0]              ch_sel,
  input  logic                         src_sel,
  input  logic [NIB_W-1:0]             acc_in,
  input  logic [NIB_W-1:0]             sub_in,
  input  logic [2*NIB_W-1:0]           pat_in,
  output logic [NUM_CH-1:0]            wr_en,
  output logic [NUM_CH-1:0][NIB_W-1:0] wr_data
);
  import nio_pkg::*;

  nio_op_e          kind;
  logic [NIB_W-1:0] word;

  assign kind = nio_op_e'(op);
  assign word = src_sel ? sub_in : acc_in;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam bit IS_HI = (c == NUM_CH - 1);
    localparam bit IS_LO = (c == NUM_CH - 2);
    always_comb begin
      wr_en[c]   = (kind == NIO_WRITE) && (ch_sel == CH_W'(c));
      wr_data[c] = word;
      if (kind == NIO_PATTERN) begin
        if (IS_HI) begin
          wr_en[c]   = 1'b1;
          wr_data[c] = pat_in[2*NIB_W-1:NIB_W];
        end else if (IS_LO) begin
          wr_en[c]   = 1'b1;
          wr_data[c] = pat_in[NIB_W-1:0];
        end
      end
    end
  end
endmodule

// File: rtl/nio_latch_bank.sv
module nio_latch_bank #(
  parameter int NUM_CH = 4,
  parameter int NIB_W  = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [NUM_CH-1:0]            wr_en,
  input  logic [NUM_CH-1:0][NIB_W-1:0] wr_data,
  output logic [NUM_CH-1:0][NIB_W-1:0] latch_q
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_lat
    always_ff @(posedge clk) begin
      if (rst)            latch_q[c] <= '1;
      else if (wr_en[c])  latch_q[c] <= wr_data[c];
    end
  end
endmodule

// File: rtl/nio_read_path.sv
module nio_read_path #(
  parameter int NUM_CH = 4,
  parameter int NIB_W  = 4,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [1:0]                   op,
  input  logic [CH_W-1:0]              ch_sel,
  input  logic                         src_sel,
  input  logic [NUM_CH-1:0][NIB_W-1:0] latch_q,
  input  logic [NUM_CH-1:0][NIB_W-1:0] pins,
  output logic                         rd_valid,
  output logic                         rd_to_sub,
  output logic [NIB_W-1:0]             rd_data
);
  import nio_pkg::*;

  logic             is_read;
  logic [NIB_W-1:0] wired;

  assign is_read = (nio_op_e'(op) == NIO_READ);
  assign wired   = latch_q[ch_sel] & pins[ch_sel];

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid  <= 1'b0;
      rd_to_sub <= 1'b0;
      rd_data   <= '0;
    end else begin
      rd_valid <= is_read;
      if (is_read) begin
        rd_to_sub <= src_sel;
        rd_data   <= wired;
      end
    end
  end
endmodule

// File: rtl/nio_bank.sv
module nio_bank #(
  parameter int NUM_CH = 4,
  parameter int NIB_W  = 4,
  localparam int CH_W  = $clog2(NUM_CH),
  localparam int PIN_W = NUM_CH * NIB_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [1:0]         op,
  input  logic [CH_W-1:0]    ch_sel,
  input  logic               src_sel,
  input  logic [NIB_W-1:0]   acc_in,
  input  logic [NIB_W-1:0]   sub_in,
  input  logic [2*NIB_W-1:0] pat_in,
  input  logic [PIN_W-1:0]   pin_in,
  output logic [PIN_W-1:0]   pin_out,
  output logic               rd_valid,
  output logic               rd_to_sub,
  output logic [NIB_W-1:0]   rd_data
);
  logic [NUM_CH-1:0]            wr_en;
  logic [NUM_CH-1:0][NIB_W-1:0] wr_data;
  logic [NUM_CH-1:0][NIB_W-1:0] latch_q;
  logic [NUM_CH-1:0][NIB_W-1:0] pins;

  assign pins    = pin_in;
  assign pin_out = latch_q;

  nio_decode #(.NUM_CH(NUM_CH), .NIB_W(NIB_W)) u_dec (
    .op(op), .ch_sel(ch_sel), .src_sel(src_sel), .acc_in(acc_in),
    .sub_in(sub_in), .pat_in(pat_in), .wr_en(wr_en), .wr_data(wr_data)
  );

  nio_latch_bank #(.NUM_CH(NUM_CH), .NIB_W(NIB_W)) u_lat (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .latch_q(latch_q)
  );

  nio_read_path #(.NUM_CH(NUM_CH), .NIB_W(NIB_W)) u_rd (
    .clk(clk), .rst(rst), .op(op), .ch_sel(ch_sel), .src_sel(src_sel),
    .latch_q(latch_q), .pins(pins), .rd_valid(rd_valid),
    .rd_to_sub(rd_to_sub), .rd_data(rd_data)
  );
endmodule

// File: rtl/nio_bank_checker.sv
module nio_bank_checker #(
  parameter int NUM_CH = 4,
  parameter int NIB_W  = 4,
  localparam int CH_W  = $clog2(NUM_CH),
  localparam int PIN_W = NUM_CH * NIB_W
) (
  input logic               clk,
  input logic               rst,
  input logic [1:0]         op,
  input logic [CH_W-1:0]    ch_sel,
  input logic               src_sel,
  input logic [2*NIB_W-1:0] pat_in,
  input logic [PIN_W-1:0]   pin_in,
  input logic [PIN_W-1:0]   pin_out,
  input logic               rd_valid,
  input logic               rd_to_sub,
  input logic [NIB_W-1:0]   rd_data
);
  localparam int LO_W = PIN_W - 2 * NIB_W;

  logic [NIB_W-1:0] sel_wired;
  assign sel_wired = pin_out[ch_sel*NIB_W +: NIB_W] & pin_in[ch_sel*NIB_W +: NIB_W];

  assert_reset_ones_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pin_out == '1) && !rd_valid);

  assert_pattern_fill_R4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op) == 2'd2) |->
      (pin_out[PIN_W-1:LO_W] == $past(pat_in)) && (pin_out[LO_W-1:0] == $past(pin_out[LO_W-1:0])));

  assert_read_wired_R5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op) == 2'd3) |-> rd_valid && (rd_data == $past(sel_wired)));

  assert_read_dest_R6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op) == 2'd3) |-> (rd_to_sub == $past(src_sel)));

  assert_latch_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(op) == 2'd0 || $past(op) == 2'd3)) |-> $stable(pin_out));

  assert_valid_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op) != 2'd3) |-> !rd_valid);
endmodule

bind nio_bank nio_bank_checker #(.NUM_CH(NUM_CH), .NIB_W(NIB_W)) u_chk (
  .clk(clk), .rst(rst), .op(op), .ch_sel(ch_sel), .src_sel(src_sel),
  .pat_in(pat_in), .pin_in(pin_in), .pin_out(pin_out), .rd_valid(rd_valid),
  .rd_to_sub(rd_to_sub), .rd_data(rd_data)
);

// File: tb/test_nio_bank.sv
module test_nio_bank;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  op = 2'd0;
  logic [1:0]  ch_sel = '0;
  logic        src_sel = 1'b0;
  logic [3:0]  acc_in = '0;
  logic [3:0]  sub_in = '0;
  logic [7:0]  pat_in = '0;
  logic [15:0] pin_in = '0;
  logic [15:0] pin_out;
  logic        rd_valid;
  logic        rd_to_sub;
  logic [3:0]  rd_data;

  int          n_chk = 0;
  int          n_bad = 0;
  logic [15:0] exp_pins = 16'hFFFF;
  logic        done = 1'b0;

  always #4 clk = ~clk;

  nio_bank i_nio_bank (
    .clk(clk), .rst(rst), .op(op), .ch_sel(ch_sel), .src_sel(src_sel),
    .acc_in(acc_in), .sub_in(sub_in), .pat_in(pat_in), .pin_in(pin_in),
    .pin_out(pin_out), .rd_valid(rd_valid), .rd_to_sub(rd_to_sub), .rd_data(rd_data)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // apply one operation at a falling edge; outputs are sampled at the next falling edge
  task automatic apply(input logic [1:0] o, input logic [1:0] c, input logic s,
                       input logic [3:0] a, input logic [3:0] b, input logic [7:0] p);
    op = o; ch_sel = c; src_sel = s; acc_in = a; sub_in = b; pat_in = p;
    @(negedge clk);
    op = 2'd0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 pins", pin_out, 16'hFFFF);
    check("R1 valid", {15'd0, rd_valid}, 16'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after release", pin_out, 16'hFFFF);

    // R2 / R3: every channel, both sources, every value
    for (int c = 0; c < 4; c++) begin
      for (int s = 0; s < 2; s++) begin
        for (int v = 0; v < 16; v++) begin
          apply(2'd1, 2'(c), 1'(s), 4'(v), 4'(15 - v), 8'hA5);
          exp_pins[c*4 +: 4] = (s == 1) ? 4'(15 - v) : 4'(v);
          check(s ? "R3 write sub" : "R2 write acc", pin_out, exp_pins);
          check("R8 no pulse on write", {15'd0, rd_valid}, 16'd0);
        end
      end
    end

    // R4: all pattern words, noise on the other inputs
    for (int p = 0; p < 256; p++) begin
      apply(2'd2, 2'(p % 4), 1'(p % 2), 4'(p), 4'(p >> 3), 8'(p));
      exp_pins[15:8] = 8'(p);
      check("R4 pattern", pin_out, exp_pins);
    end

    // R5 / R6 / R7 / R8: wired-AND readback sweep
    for (int c = 0; c < 4; c++) begin
      for (int l = 0; l < 16; l++) begin
        apply(2'd1, 2'(c), 1'b0, 4'(l), 4'd0, 8'd0);
        exp_pins[c*4 +: 4] = 4'(l);
        for (int p = 0; p < 16; p++) begin
          pin_in = '0;
          pin_in[c*4 +: 4] = 4'(p);
          apply(2'd3, 2'(c), 1'((l + p) % 2), 4'hF, 4'hF, 8'hFF);
          check("R5 read data", {12'd0, rd_data}, {12'd0, 4'(l & p)});
          check("R5 read valid", {15'd0, rd_valid}, 16'd1);
          check("R6 destination", {15'd0, rd_to_sub}, {15'd0, 1'((l + p) % 2)});
          check("R7 read keeps latches", pin_out, exp_pins);
        end
      end
    end

    // R7 / R8: no-op holds latches, pulse ends
    apply(2'd0, 2'd1, 1'b1, 4'h0, 4'h0, 8'h00);
    check("R7 nop", pin_out, exp_pins);
    check("R8 pulse ends", {15'd0, rd_valid}, 16'd0);

    // R1: reset again restores all ones
    rst = 1'b1;
    @(negedge clk);
    check("R1 re-reset", pin_out, 16'hFFFF);
    rst = 1'b0;
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (50000) @(negedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule